// File: doc/BRIEF.md
# Predicated SIMD Writeback Mask Unit

This unit sits between a 64-bit SIMD ALU and a register file whose write port has one enable per byte. For each result it receives an element-width code, up to eight predicate bits, a predicate-invert control, a zeroing-mode control and the 64-bit ALU result. It turns these into 64-bit write data and an 8-bit byte write-enable vector. The result passes through one registered stage with a valid/ready handshake.

The predicate is expanded to byte enables according to the element width, so one bit covers 8, 4, 2 or 1 bytes. In merging (non-zeroing) mode, masked-out elements keep their old register contents only because their byte enables are dropped. No read-modify-write of the destination is ever needed. In zeroing mode every byte is written, and the bytes of masked-out elements carry zero. An unpredicated operation is issued with the predicate at all ones and the invert control low.

Top module: `pred_wb_mask`

## Requirements
- R1: The element-width code `width_i` selects the element size: 2'b00 = 64-bit (one element, predicate bit 0), 2'b01 = 32-bit (bits 1:0), 2'b10 = 16-bit (bits 3:0), 2'b11 = 8-bit (bits 7:0). Predicate bit i governs element i, and element 0 occupies the least significant bytes.
- R2: Predicate bits above the element count of the selected width have no effect on `wdata_o` or `wbe_o`.
- R3: When `pred_inv_i` is 1, every predicate bit is complemented before it is applied.
- R4: In merging mode (`zero_mode_i` = 0), byte enable b is the effective predicate bit of the element that holds byte b, and `wdata_o` equals the captured `data_i` unchanged.
- R5: In zeroing mode (`zero_mode_i` = 1), all 8 byte enables are 1, and each byte of a masked-out element is 8'h00 while the bytes of active elements carry `data_i`.
- R6: With `pred_i` = 8'hFF and `pred_inv_i` = 0, all byte enables are 1 and `wdata_o` equals `data_i` in either mode and at every width.
- R7: An input is captured at a clock edge when `valid_i` and `ready_o` are both 1, and then `valid_o` is 1. `ready_o` is 1 when `ready_i` is 1 or the output stage is empty.
- R8: `wbe_o` is all zeros whenever `valid_o` is 0, including right after reset.
- R9: While `valid_o` is 1 and `ready_i` is 0, `wdata_o` and `wbe_o` hold their values and `valid_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input beat present |
| ready_o | output | 1 | Unit can accept a beat |
| width_i | input | 2 | Element-width code |
| pred_i | input | 8 | Predicate bits, bit i for element i |
| pred_inv_i | input | 1 | Complement the predicate |
| zero_mode_i | input | 1 | 1 = zeroing, 0 = merging |
| data_i | input | 64 | ALU result |
| valid_o | output | 1 | Output beat present |
| ready_i | input | 1 | Downstream accepts |
| wdata_o | output | 64 | Register-file write data |
| wbe_o | output | 8 | Byte write enables |

## Verification
The hardest case to reach from the ports is a back-pressure stall: a beat is held in the output stage while a different beat waits at the input, and it is then released in the same cycle the new beat is taken. The bench builds this on purpose. It loads one beat, drops `ready_i` while a second beat with different width, mode and data sits at the input, checks that the outputs stay frozen and that `ready_o` is low, and then raises `ready_i` so the handover happens at one edge. Random beats with noisy upper predicate bits cover the width, invert and mode mix around it.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    EW_64 = 2'b00,
    EW_32 = 2'b01,
    EW_16 = 2'b10,
    EW_8  = 2'b11
  } elem_w_e;
endpackage

// File: rtl/pwm_expand.sv
module pwm_expand #(
  parameter int NBYTE  = 8,
  parameter int WSEL_W = 2
) (
  input  logic [WSEL_W-1:0] width_i,
  input  logic [NBYTE-1:0]  pred_i,
  input  logic              inv_i,
  output logic [NBYTE-1:0]  byte_en_o
);
  localparam int LG = $clog2(NBYTE);

  logic [NBYTE-1:0] eff_pred;
  assign eff_pred = pred_i ^ {NBYTE{inv_i}};

  // width code k: elements of NBYTE>>k bytes, byte b in element b>>(LG-k)
  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    logic en;
    always_comb begin
      en = eff_pred[0];
      for (int k = 0; k <= LG; k++) begin
        if (width_i == WSEL_W'(k)) en = eff_pred[b >> (LG - k)];
      end
    end
    assign byte_en_o[b] = en;
  end
endmodule

// File: rtl/pwm_apply.sv
module pwm_apply #(
  parameter int NBYTE = 8
) (
  input  logic                           zero_mode_i,
  input  logic [NBYTE-1:0]               byte_en_i,
  input  logic [NBYTE*pwm_pkg::BYTE_W-1:0] data_i,
  output logic [NBYTE*pwm_pkg::BYTE_W-1:0] wdata_o,
  output logic [NBYTE-1:0]               wbe_o
);
  localparam int BW = pwm_pkg::BYTE_W;

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    assign wdata_o[b*BW +: BW] = (zero_mode_i && !byte_en_i[b]) ? '0 : data_i[b*BW +: BW];
  end

  // merging mode: gating enables is the whole job
  assign wbe_o = zero_mode_i ? {NBYTE{1'b1}} : byte_en_i;
endmodule

// File: rtl/pwm_out_reg.sv
module pwm_out_reg #(
  parameter int NBYTE = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           valid_i,
  output logic                           ready_o,
  input  logic [NBYTE*pwm_pkg::BYTE_W-1:0] wdata_i,
  input  logic [NBYTE-1:0]               wbe_i,
  output logic                           valid_o,
  input  logic                           ready_i,
  output logic [NBYTE*pwm_pkg::BYTE_W-1:0] wdata_o,
  output logic [NBYTE-1:0]               wbe_o
);
  localparam int DW = NBYTE * pwm_pkg::BYTE_W;

  logic          valid_q;
  logic [DW-1:0] wdata_q;
  logic [NBYTE-1:0] wbe_q;
  logic          load;

  assign ready_o = ready_i || !valid_q;
  assign load    = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      wdata_q <= '0;
      wbe_q   <= '0;
    end else begin
      if (load) begin
        valid_q <= 1'b1;
        wdata_q <= wdata_i;
        wbe_q   <= wbe_i;
      end else if (ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
  assign wdata_o = wdata_q;
  assign wbe_o   = valid_q ? wbe_q : '0;

  // R8
  idle_no_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (wbe_o == '0));

  // R7
  accept_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> valid_o);

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(wdata_o) && $stable(wbe_o)));
endmodule

// File: rtl/pred_wb_mask.sv
module pred_wb_mask #(
  parameter int DATA_W = 64,
  localparam int NBYTE  = DATA_W / pwm_pkg::BYTE_W,
  localparam int LG     = $clog2(NBYTE),
  localparam int WSEL_W = $clog2(LG + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [WSEL_W-1:0] width_i,
  input  logic [NBYTE-1:0]  pred_i,
  input  logic              pred_inv_i,
  input  logic              zero_mode_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [NBYTE-1:0]  wbe_o
);
  logic [NBYTE-1:0]  byte_en;
  logic [DATA_W-1:0] mdata;
  logic [NBYTE-1:0]  mbe;

  pwm_expand #(.NBYTE(NBYTE), .WSEL_W(WSEL_W)) u_expand (
    .width_i  (width_i),
    .pred_i   (pred_i),
    .inv_i    (pred_inv_i),
    .byte_en_o(byte_en)
  );

  pwm_apply #(.NBYTE(NBYTE)) u_apply (
    .zero_mode_i(zero_mode_i),
    .byte_en_i  (byte_en),
    .data_i     (data_i),
    .wdata_o    (mdata),
    .wbe_o      (mbe)
  );

  pwm_out_reg #(.NBYTE(NBYTE)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .ready_o(ready_o),
    .wdata_i(mdata),
    .wbe_i  (mbe),
    .valid_o(valid_o),
    .ready_i(ready_i),
    .wdata_o(wdata_o),
    .wbe_o  (wbe_o)
  );

  // R5
  zero_all_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && zero_mode_i) |=> (wbe_o == '1));

  // R1
  full_word_uniform_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && width_i == '0) |=>
      ($countones(wbe_o) == 0 || $countones(wbe_o) == NBYTE));
endmodule

// File: tb/pred_wb_mask_bench.sv
module pred_wb_mask_bench;
  import pwm_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        ready_o;
  logic [1:0]  width_i = '0;
  logic [7:0]  pred_i = '0;
  logic        inv_i = 1'b0;
  logic        zm_i = 1'b0;
  logic [63:0] data_i = '0;
  logic        valid_o;
  logic        ready_i = 1'b0;
  logic [63:0] wdata_o;
  logic [7:0]  wbe_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pred_wb_mask u_pred_wb_mask (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .ready_o(ready_o),
    .width_i(width_i), .pred_i(pred_i), .pred_inv_i(inv_i), .zero_mode_i(zm_i),
    .data_i(data_i), .valid_o(valid_o), .ready_i(ready_i),
    .wdata_o(wdata_o), .wbe_o(wbe_o)
  );

  function automatic logic [7:0] exp_be(logic [1:0] w, logic [7:0] p, logic inv, logic zm);
    logic [7:0] m;
    logic [7:0] r;
    int bytes_per_el;
    m = p ^ {8{inv}};
    bytes_per_el = 8 >> w;
    for (int b = 0; b < 8; b++) r[b] = m[b / bytes_per_el];
    return zm ? 8'hFF : r;
  endfunction

  function automatic logic [63:0] exp_data(logic [1:0] w, logic [7:0] p, logic inv, logic zm,
                                           logic [63:0] d);
    logic [7:0] act;
    logic [63:0] r;
    act = exp_be(w, p, inv, 1'b0);
    r = d;
    if (zm) for (int b = 0; b < 8; b++) if (!act[b]) r[b*8 +: 8] = 8'h00;
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_in(logic [1:0] w, logic [7:0] p, logic inv, logic zm, logic [63:0] d);
    width_i = w; pred_i = p; inv_i = inv; zm_i = zm; data_i = d;
  endtask

  // one beat through an always-ready downstream, checked after its capture edge
  task automatic beat(string req, logic [1:0] w, logic [7:0] p, logic inv, logic zm,
                      logic [63:0] d);
    @(negedge clk);
    set_in(w, p, inv, zm, d);
    valid_i = 1'b1;
    ready_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check({req, " valid"}, 64'(valid_o), 64'd1);
    check({req, " wbe"}, 64'(wbe_o), 64'(exp_be(w, p, inv, zm)));
    check({req, " wdata"}, wdata_o, exp_data(w, p, inv, zm, d));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] d0;
    process::self().srandom(32'd1234);
    d0 = 64'h0123_4567_89AB_CDEF;
    repeat (3) @(negedge clk);
    // R8 reset state, R7 empty stage ready
    check("R8 reset valid", 64'(valid_o), 64'd0);
    check("R8 reset wbe", 64'(wbe_o), 64'd0);
    check("R7 reset ready", 64'(ready_o), 64'd1);
    rst_n = 1'b1;

    // R1 element mapping per width, single active element
    beat("R1 w64", EW_64, 8'h01, 1'b0, 1'b0, d0);
    beat("R1 w32 el1", EW_32, 8'h02, 1'b0, 1'b0, d0);
    check("R1 w32 el1 upper", 64'(wbe_o), 64'hF0);
    beat("R1 w16 el2", EW_16, 8'h04, 1'b0, 1'b0, d0);
    check("R1 w16 el2 bytes", 64'(wbe_o), 64'h30);
    beat("R1 w8 el5", EW_8, 8'h20, 1'b0, 1'b0, d0);
    // R2 unused bits have no effect
    beat("R2 w64 noise", EW_64, 8'hFE, 1'b0, 1'b0, d0);
    check("R2 w64 none", 64'(wbe_o), 64'h00);
    beat("R2 w16 noise", EW_16, 8'hA5, 1'b0, 1'b1, d0);
    // R3 inversion
    beat("R3 w8 inv", EW_8, 8'h0F, 1'b1, 1'b0, d0);
    check("R3 w8 inv bytes", 64'(wbe_o), 64'hF0);
    beat("R3 w32 inv zero", EW_32, 8'h01, 1'b1, 1'b1, d0);
    check("R3 w32 inv data", wdata_o, 64'h0123_4567_0000_0000);
    // R4 merging keeps data, R5 zeroing clears lanes
    beat("R4 w16 merge", EW_16, 8'h05, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    beat("R5 w16 zero", EW_16, 8'h05, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R5 w16 zero data", wdata_o, 64'h0000_FFFF_0000_FFFF);
    beat("R5 w64 all off", EW_64, 8'h00, 1'b0, 1'b1, d0);
    // R6 unpredicated
    for (int w = 0; w < 4; w++) begin
      beat("R6 merge", 2'(w), 8'hFF, 1'b0, 1'b0, d0);
      beat("R6 zero", 2'(w), 8'hFF, 1'b0, 1'b1, d0);
    end

    // R9 stall with a different beat waiting, then R7 handover
    @(negedge clk);
    set_in(EW_8, 8'h3C, 1'b0, 1'b0, 64'hDEAD_BEEF_CAFE_F00D);
    valid_i = 1'b1; ready_i = 1'b1;
    @(negedge clk);
    ready_i = 1'b0;
    set_in(EW_32, 8'h01, 1'b1, 1'b1, 64'h1111_2222_3333_4444);
    #1;
    check("R7 stall ready low", 64'(ready_o), 64'd0);
    repeat (3) @(negedge clk);
    check("R9 stall valid", 64'(valid_o), 64'd1);
    check("R9 stall wbe", 64'(wbe_o), 64'h3C);
    check("R9 stall data", wdata_o, 64'hDEAD_BEEF_CAFE_F00D);
    ready_i = 1'b1;
    #1;
    check("R7 ready follows downstream", 64'(ready_o), 64'd1);
    @(negedge clk);
    valid_i = 1'b0;
    check("R7 handover wbe", 64'(wbe_o), 64'hFF);
    check("R7 handover data", wdata_o, 64'h1111_2222_0000_0000);
    @(negedge clk);
    check("R8 drained valid", 64'(valid_o), 64'd0);
    check("R8 drained wbe", 64'(wbe_o), 64'd0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] w;
      logic zm;
      w = 2'($urandom_range(3));
      zm = 1'($urandom);
      beat(zm ? "R5 rand" : "R4 rand", w, 8'($urandom), 1'($urandom), zm,
           {$urandom, $urandom});
      if ($urandom_range(3) == 0) begin
        @(negedge clk);
        check("R8 rand idle wbe", 64'(wbe_o), 64'd0);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule